// File: doc/BRIEF.md
# Condition Flag Unit

This unit keeps the four condition flags of an integer pipeline: negative (N), zero (Z), carry (C) and overflow (V). When an arithmetic or logical operation completes, the surrounding datapath presents the two operands, the result already produced by its adder or logic unit, an operation class and a width select. The unit then derives the new flags in one clock, for either the 32-bit or the 64-bit view of the operands. Instruction decode and the adder itself belong to the neighbouring blocks.

The flags can also be written and read as a 32-bit status word. This lets a context switch or an explicit status-register move save and restore them. A 4-bit condition code is evaluated against the flags currently held, which gives a single taken signal for branches, conditional selects and conditional execution.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags, so the status word reads zero in the cycle after reset.
- R2: The status word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28, and every other bit reads zero. A status write loads the flags from those same bit positions and ignores the rest.
- R3: A status write takes priority over an operation update in the same cycle. With neither a status write nor an enabled update, the flags keep their value.
- R4: N is the result's bit 31 and Z is set when result bits 31..0 are all zero when the width select is 0 (32-bit). N is bit 63 and Z covers all 64 bits when the width select is 1. In 32-bit mode the upper operand and result bits have no effect.
- R5: For an add (class 0), C is set when the unsigned result is less than operand A. V is set when the result's sign differs from the signs of both A and B.
- R6: For a subtract (class 1), C is set when A is greater than or equal to B as unsigned values, so C means no borrow. V is set when A and B have different signs and the result's sign differs from A's.
- R7: For a logical operation (class 2), N and Z follow the result, and C and V are cleared.
- R8: Operation class 3 is reserved. With the update enable high it leaves the flags unchanged.
- R9: Condition codes 0 to 7 test Z, C, N and V in that pair order. An even code is true when its flag is set and an odd code is true when it is clear.
- R10: Code 8 is true when C is set and Z is clear, and code 9 is its complement.
- R11: Code 10 is true when N equals V and code 11 is its complement. Code 12 is true when Z is clear and N equals V, and code 13 is its complement.
- R12: Codes 14 and 15 are always true, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opRes | input | 64 | Result produced by the external adder or logic unit |
| opClass | input | 2 | 0 add, 1 subtract, 2 logical, 3 reserved |
| wide | input | 1 | 1 selects 64-bit flags, 0 selects 32-bit flags |
| updEn | input | 1 | Apply an operation update at the next edge |
| statWrEn | input | 1 | Load the flags from statWrData at the next edge |
| statWrData | input | 32 | Status word to load |
| condCode | input | 4 | Condition code to evaluate |
| statRd | output | 32 | Current flags packed as a status word |
| condTaken | output | 1 | Result of evaluating condCode against the current flags |

## Verification
The update path is tried with pairs whose signs and magnitudes bring out each flag on its own. Signed overflow without unsigned carry, unsigned wraparound to zero, a borrow against no borrow, and an equal-operand subtract that sets both Z and C each tell the carry and overflow formulas apart. The same bit patterns are run in 32-bit and 64-bit modes, with upper bits set that would change the answer if the wrong width were used. Logical results are applied on top of flags that already have C and V set, so a missing clear shows up. Every condition code is evaluated against all sixteen flag combinations, which separates each code from its complement and from its neighbours.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_NONE  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic loadWord;
    logic loadOp;
  } strobe_t;

  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/cfu_ctrl.sv
module cfu_ctrl
  import cfu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      updEn,
  input  logic      statWrEn,
  input  opClass_e  opClass,
  output strobe_t   strb
);

  logic opValid;

  always_comb begin
    opValid = 1'b0;
    unique case (opClass)
      CLS_ADD, CLS_SUB, CLS_LOGIC: opValid = 1'b1;
      default:                     opValid = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (!rst) begin
      if (statWrEn) begin
        strb.loadWord = 1'b1;
      end else if (updEn && opValid) begin
        strb.loadOp = 1'b1;
      end
    end
  end

  // R3: the two load strobes never fire together
  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadWord, strb.loadOp}));

  // R3: a status write wins over an operation update
  a_r3_word_priority: assert property (@(posedge clk) disable iff (rst)
    (statWrEn && updEn) |-> !strb.loadOp);

  // R8: the reserved class never produces an update
  a_r8_reserved_class: assert property (@(posedge clk) disable iff (rst)
    (opClass == CLS_NONE) |-> !strb.loadOp);

endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  flags_t      flags,
  input  logic [3:0]  condCode,
  output logic        condTaken
);

  logic baseTrue;
  logic invertSel;

  always_comb begin
    baseTrue = 1'b1;
    unique case (condCode[3:1])
      3'd0: baseTrue = flags.z;
      3'd1: baseTrue = flags.c;
      3'd2: baseTrue = flags.n;
      3'd3: baseTrue = flags.v;
      3'd4: baseTrue = flags.c & ~flags.z;
      3'd5: baseTrue = ~(flags.n ^ flags.v);
      3'd6: baseTrue = ~flags.z & ~(flags.n ^ flags.v);
      default: baseTrue = 1'b1;
    endcase
  end

  assign invertSel = condCode[0] & (condCode[3:1] != 3'b111);
  assign condTaken = baseTrue ^ invertSel;

  // R12: the top pair of codes is always true
  always_comb begin
    if (condCode[3:1] == 3'b111) begin
      a_r12_always_true: assert (condTaken);
    end
  end

endmodule

// File: rtl/cfu_datapath.sv
module cfu_datapath
  import cfu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int HALF_W   = 32,
  parameter int STAT_W   = 32,
  parameter int FLAG_MSB = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opRes,
  input  opClass_e          opClass,
  input  logic              wide,
  input  logic [STAT_W-1:0] statWrData,
  output flags_t            flagsQ,
  output logic [STAT_W-1:0] statRd
);

  localparam int NUM_LANES = 2;
  localparam int FLAG_LSB  = FLAG_MSB - NUM_FLAGS + 1;

  flags_t laneFlags [NUM_LANES];
  flags_t opFlags;
  flags_t wordFlags;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
      localparam int LW = (g == 0) ? HALF_W : DATA_W;
      logic [LW-1:0] la, lb, lr;
      logic sa, sb, sr;
      flags_t lf;

      assign la = opA[LW-1:0];
      assign lb = opB[LW-1:0];
      assign lr = opRes[LW-1:0];
      assign sa = la[LW-1];
      assign sb = lb[LW-1];
      assign sr = lr[LW-1];

      always_comb begin
        lf.n = sr;
        lf.z = (lr == '0);
        unique case (opClass)
          CLS_ADD: begin
            lf.c = (lr < la);
            lf.v = (sa ^ sr) & (sb ^ sr);
          end
          CLS_SUB: begin
            lf.c = (la >= lb);
            lf.v = (sa ^ sb) & (sa ^ sr);
          end
          default: begin
            lf.c = 1'b0;
            lf.v = 1'b0;
          end
        endcase
      end

      assign laneFlags[g] = lf;
    end
  endgenerate

  assign opFlags = wide ? laneFlags[1] : laneFlags[0];

  always_comb begin
    wordFlags.n = statWrData[FLAG_MSB];
    wordFlags.z = statWrData[FLAG_MSB-1];
    wordFlags.c = statWrData[FLAG_MSB-2];
    wordFlags.v = statWrData[FLAG_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ <= '0;
    end else if (strb.loadWord) begin
      flagsQ <= wordFlags;
    end else if (strb.loadOp) begin
      flagsQ <= opFlags;
    end
  end

  always_comb begin
    statRd = '0;
    statRd[FLAG_MSB:FLAG_LSB] = flagsQ;
  end

  // R1: flags are clear in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flagsQ == '0));

  // R3: no load strobe means the flags are held
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadWord && !strb.loadOp) |=> $stable(flagsQ));

  // R2: a status write lands in the packed word at the same positions
  a_r2_word_roundtrip: assert property (@(posedge clk) disable iff (rst)
    strb.loadWord |=> (statRd[FLAG_MSB:FLAG_LSB] == $past(statWrData[FLAG_MSB:FLAG_LSB])));

  // R7: logical updates clear carry and overflow
  a_r7_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (strb.loadOp && opClass == CLS_LOGIC) |=> (!flagsQ.c && !flagsQ.v));

  // R6: 64-bit subtract carry is the unsigned no-borrow test
  a_r6_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (strb.loadOp && opClass == CLS_SUB && wide) |=> (flagsQ.c == ($past(opA) >= $past(opB))));

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int HALF_W   = 32,
  parameter int STAT_W   = 32,
  parameter int FLAG_MSB = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opRes,
  input  logic [1:0]        opClass,
  input  logic              wide,
  input  logic              updEn,
  input  logic              statWrEn,
  input  logic [STAT_W-1:0] statWrData,
  input  logic [3:0]        condCode,
  output logic [STAT_W-1:0] statRd,
  output logic              condTaken
);

  strobe_t  strb;
  flags_t   flagsQ;
  opClass_e opClassE;

  assign opClassE = opClass_e'(opClass);

  cfu_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .updEn    (updEn),
    .statWrEn (statWrEn),
    .opClass  (opClassE),
    .strb     (strb)
  );

  cfu_datapath #(
    .DATA_W   (DATA_W),
    .HALF_W   (HALF_W),
    .STAT_W   (STAT_W),
    .FLAG_MSB (FLAG_MSB)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .opA        (opA),
    .opB        (opB),
    .opRes      (opRes),
    .opClass    (opClassE),
    .wide       (wide),
    .statWrData (statWrData),
    .flagsQ     (flagsQ),
    .statRd     (statRd)
  );

  cfu_cond_eval uCond (
    .flags     (flagsQ),
    .condCode  (condCode),
    .condTaken (condTaken)
  );

endmodule

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opA = '0, opB = '0, opRes = '0;
  logic [1:0]  opClass = 2'd0;
  logic        wide = 1'b0, updEn = 1'b0, statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic [3:0]  condCode = '0;
  logic [31:0] statRd;
  logic        condTaken;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [3:0] mF = '0; // model flags {N,Z,C,V}

  always #4 clk = ~clk; // 125 MHz

  cond_flag_unit dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opRes(opRes),
    .opClass(opClass), .wide(wide), .updEn(updEn), .statWrEn(statWrEn),
    .statWrData(statWrData), .condCode(condCode),
    .statRd(statRd), .condTaken(condTaken)
  );

  function automatic logic [3:0] refFlags(input logic [63:0] a, b, r,
                                          input logic [1:0] cls, input logic w);
    logic [63:0] ma, mb, mr;
    logic sa, sb, sr, n, z, c, v;
    ma = w ? a : {32'd0, a[31:0]};
    mb = w ? b : {32'd0, b[31:0]};
    mr = w ? r : {32'd0, r[31:0]};
    sa = w ? a[63] : a[31];
    sb = w ? b[63] : b[31];
    sr = w ? r[63] : r[31];
    n = sr;
    z = (mr == 64'd0);
    c = 1'b0;
    v = 1'b0;
    if (cls == 2'd0) begin
      c = mr < ma;
      v = (sa != sr) && (sb != sr);
    end else if (cls == 2'd1) begin
      c = ma >= mb;
      v = (sa != sb) && (sr != sa);
    end
    return {n, z, c, v};
  endfunction

  function automatic logic refCond(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !(c && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, update the model, queue the expectation
  task automatic drive(input logic we, input logic [31:0] wd, input logic ue,
                       input logic [1:0] cls, input logic w,
                       input logic [63:0] a, b, r, input string tag);
    @(negedge clk);
    statWrEn = we; statWrData = wd; updEn = ue; opClass = cls; wide = w;
    opA = a; opB = b; opRes = r;
    @(posedge clk);
    if (we) mF = wd[31:28];
    else if (ue && cls != 2'd3) mF = refFlags(a, b, r, cls, w);
    sbq.push_back('{exp: {mF, 28'd0}, tag: tag});
    @(negedge clk);
    statWrEn = 1'b0; updEn = 1'b0;
  endtask

  task automatic writeWord(input logic [31:0] wd, input string tag);
    drive(1'b1, wd, 1'b0, 2'd0, 1'b0, '0, '0, '0, tag);
  endtask

  task automatic doOp(input logic [1:0] cls, input logic w,
                      input logic [63:0] a, b, r, input string tag);
    drive(1'b0, '0, 1'b1, cls, w, a, b, r, tag);
  endtask

  // Monitor: pop and compare at the falling edge after each update
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (statRd !== it.exp) begin
        errors++;
        $display("FAIL %s: statRd=%h expected=%h", it.tag, statRd, it.exp);
      end
    end
  end

  task automatic sweepCond(input string ctx);
    for (int code = 0; code < 16; code++) begin
      logic e;
      string tag;
      condCode = code[3:0];
      #1;
      e = refCond(code[3:0], mF);
      if (code < 8) tag = "R9";
      else if (code < 10) tag = "R10";
      else if (code < 14) tag = "R11";
      else tag = "R12";
      checks++;
      if (condTaken !== e) begin
        errors++;
        $display("FAIL %s code=%0d flags=%b (%s): taken=%b expected=%b",
                 tag, code, mF, ctx, condTaken, e);
      end
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (statRd !== 32'd0) begin
      errors++;
      $display("FAIL R1: statRd=%h expected=%h", statRd, 32'd0);
    end

    // R2: status word packing, other bits ignored
    writeWord(32'hA000_0000, "R2 write N,C");
    writeWord(32'hFFFF_FFFF, "R2 other bits read zero");
    writeWord(32'h5ABC_DEF1, "R2 write Z,V");

    // R5: add, 64-bit
    doOp(2'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, "R5 signed overflow");
    doOp(2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R5 carry wrap to zero");
    // R4/R5: add, 32-bit with upper bits that would differ in 64-bit mode
    doOp(2'd0, 1'b0, 64'h0000_0001_8000_0000, 64'h0000_0000_8000_0000,
         64'h0000_0002_0000_0000, "R4 32-bit zero carry overflow");
    doOp(2'd0, 1'b1, 64'h0000_0001_8000_0000, 64'h0000_0000_8000_0000,
         64'h0000_0002_0000_0000, "R4 same values 64-bit");

    // R6: subtract
    doOp(2'd1, 1'b1, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, "R6 borrow");
    doOp(2'd1, 1'b1, 64'd7, 64'd7, 64'd0, "R6 equal operands");
    doOp(2'd1, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, "R6 signed overflow");
    doOp(2'd1, 1'b0, 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_0000_0004,
         64'hFFFF_FFFF_FFFF_FFFF, "R6 32-bit borrow");

    // R7: logical ops clear C and V
    writeWord(32'h3000_0000, "R7 preset C,V");
    doOp(2'd2, 1'b1, 64'hF0, 64'h0F, 64'd0, "R7 logic zero");
    writeWord(32'h3000_0000, "R7 preset C,V again");
    doOp(2'd2, 1'b0, 64'd0, 64'd0, 64'h0000_0001_8000_0000, "R7 logic 32-bit negative");

    // R8: reserved class holds
    writeWord(32'hC000_0000, "R8 preset N,Z");
    doOp(2'd3, 1'b1, 64'd1, 64'd1, 64'd2, "R8 reserved class");

    // R3: hold without enable, and word priority
    drive(1'b0, '0, 1'b0, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R3 hold when disabled");
    drive(1'b1, 32'h1000_0000, 1'b1, 2'd0, 1'b1,
          64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R3 word beats update");

    // R9-R12: all condition codes against all flag combinations
    for (int f = 0; f < 16; f++) begin
      writeWord({f[3:0], 28'd0}, "R2 flag preset");
      sweepCond("sweep");
    end

    // R1: reset mid-run clears the flags
    writeWord(32'hF000_0000, "R2 preset before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mF = '0;
    checks++;
    if (statRd !== 32'd0) begin
      errors++;
      $display("FAIL R1 mid-run: statRd=%h expected=%h", statRd, 32'd0);
    end

    repeat (2) @(negedge clk);
    finish();
  end

endmodule